// File: doc/BRIEF.md
# Temperature Offset Correction and Limit Checker

This block sits behind a temperature measurement front end. Each time a new signed reading arrives with its valid strobe, the block adds a small programmable signed correction to the reading, clips the result to the signed range of the reading, and stores it as the corrected temperature. In the same clock cycle it compares the corrected value against an upper alarm limit, a lower alarm limit and a thermal-trip limit.

Every comparison has its own sticky status flag. A flag stays set until software-side logic sends a one-cycle clear pulse. The thermal-trip comparison also drives a level output, `therm_o`, with built-in hysteresis. That output asserts as soon as a corrected sample reaches the trip limit. It releases only after a sample falls more than a fixed margin below that limit, which stops it from chattering around the threshold.

Top module: `tmon_limit_check`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `corr_temp`, `corr_vld`, `flag_hi`, `flag_lo`, `flag_trip` and `therm_o` are all 0.
- R2: The correction `ofs_code` is a 5-bit two's-complement value that is sign-extended and added to the signed 8-bit `raw_temp`. The code 5'b10000 (-16) is applied as -15, so the usable correction is -15 to +15. The sum appears on `corr_temp` at the clock edge that samples `raw_vld` high.
- R3: The corrected sum saturates at +127 and -128 instead of wrapping.
- R4: `flag_hi` is set at a sampling edge whose corrected value is greater than the signed `lim_hi`.
- R5: `flag_lo` is set at a sampling edge whose corrected value is less than the signed `lim_lo`.
- R6: `flag_hi`, `flag_lo` and `flag_trip` are sticky. A `sts_clr` pulse clears them at the next edge. If the same edge also samples a violation, the affected flag is set.
- R7: `therm_o` and `flag_trip` are set at a sampling edge whose corrected value is greater than or equal to the signed `lim_trip`.
- R8: After `therm_o` is set, it clears only at a sampling edge whose corrected value is below `lim_trip` minus 5. The subtraction is done without wrap, so a trip limit near -128 can never release. In between, `therm_o` holds its value.
- R9: `corr_vld` is high for exactly the one cycle after each sampling edge. When `raw_vld` is low, changes on `raw_temp` or `ofs_code` leave `corr_temp`, the flags and `therm_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_temp | input | 8 | Signed raw reading |
| raw_vld | input | 1 | Reading valid strobe |
| ofs_code | input | 5 | Signed correction code |
| lim_hi | input | 8 | Signed upper alarm limit |
| lim_lo | input | 8 | Signed lower alarm limit |
| lim_trip | input | 8 | Signed thermal-trip limit |
| sts_clr | input | 1 | One-cycle clear of the sticky flags |
| corr_temp | output | 8 | Registered corrected temperature |
| corr_vld | output | 1 | Pulses high the cycle after a sample |
| flag_hi | output | 1 | Sticky upper-limit flag |
| flag_lo | output | 1 | Sticky lower-limit flag |
| flag_trip | output | 1 | Sticky thermal-trip flag |
| therm_o | output | 1 | Thermal-trip level with hysteresis |

## Verification
All state in this block is one register deep. A wrong adder, clamp or offset decode therefore shows up on `corr_temp` one cycle after the affected sample. A comparator or flag fault shows up on the flag outputs in that same cycle. The bench sweeps every raw value against every offset code and sends a clear pulse with each sample, so each flag reflects that sample alone. A fault in the hysteresis state is different: `therm_o` may look correct until the temperature next crosses into the release band. For that reason the bench keeps its own model of the trip state across the whole sweep and adds a directed case with the trip limit near the bottom of the range.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   // Clip a sum that is one bit wider than the result to the signed result range.
   function automatic logic [7:0] sat9to8(input logic [8:0] s);
      if (s[8] != s[7]) return s[8] ? 8'h80 : 8'h7F;
      return s[7:0];
   endfunction

   typedef struct packed {
      logic hi;
      logic lo;
   } win_flags_t;
endpackage

// File: rtl/tmon_ofs_add.sv
module tmon_ofs_add #(
   parameter int TEMP_W    = 8,
   parameter int OFS_W     = 5,
   parameter bit SYM_CLAMP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [TEMP_W-1:0] raw,
   input  logic                     raw_vld,
   input  logic        [OFS_W-1:0]  ofs_code,
   output logic signed [TEMP_W-1:0] corr_c,
   output logic signed [TEMP_W-1:0] corr_q,
   output logic                     vld_q
);
   localparam int SUM_W = TEMP_W + 1;
   localparam logic [OFS_W-1:0] MOST_NEG = {1'b1, {(OFS_W-1){1'b0}}};

   if (OFS_W >= TEMP_W) begin : g_bad_ofs_w
      $error("tmon_ofs_add: OFS_W must be narrower than TEMP_W");
   end

   logic signed [SUM_W-1:0] ofs_ext;
   logic signed [SUM_W-1:0] sum;

   if (SYM_CLAMP) begin : g_sym
      always_comb begin
         if (ofs_code == MOST_NEG)
            ofs_ext = -SUM_W'((2 ** (OFS_W-1)) - 1);
         else
            ofs_ext = {{(SUM_W-OFS_W){ofs_code[OFS_W-1]}}, ofs_code};
      end
   end else begin : g_full
      always_comb ofs_ext = {{(SUM_W-OFS_W){ofs_code[OFS_W-1]}}, ofs_code};
   end

   always_comb begin
      sum = {raw[TEMP_W-1], raw} + ofs_ext;
      if (sum[SUM_W-1] != sum[SUM_W-2])
         corr_c = sum[SUM_W-1] ? {1'b1, {(TEMP_W-1){1'b0}}} : {1'b0, {(TEMP_W-1){1'b1}}};
      else
         corr_c = sum[TEMP_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= raw_vld;
         if (raw_vld) corr_q <= corr_c;
      end
   end

   assert_vld_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      raw_vld |=> vld_q);
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_vld |=> $stable(corr_q));
   assert_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      raw_vld |=> corr_q == $past(corr_c));
endmodule

// File: rtl/tmon_window_cmp.sv
module tmon_window_cmp #(
   parameter int TEMP_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp,
   input  logic                     clr,
   input  logic signed [TEMP_W-1:0] corr_c,
   input  logic signed [TEMP_W-1:0] lim_hi,
   input  logic signed [TEMP_W-1:0] lim_lo,
   output tmon_pkg::win_flags_t     flags
);
   tmon_pkg::win_flags_t viol;

   always_comb begin
      viol.hi = smp && (corr_c > lim_hi);
      viol.lo = smp && (corr_c < lim_lo);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else if (clr) flags <= viol;
      else flags <= flags | viol;
   end

   assert_hi_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && corr_c > lim_hi) |=> flags.hi);
   assert_lo_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && corr_c < lim_lo) |=> flags.lo);
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.hi && !clr) |=> flags.hi);
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !smp) |=> (flags == '0));
endmodule

// File: rtl/tmon_trip_hyst.sv
module tmon_trip_hyst #(
   parameter int TEMP_W = 8,
   parameter int HYST   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp,
   input  logic                     clr,
   input  logic signed [TEMP_W-1:0] corr_c,
   input  logic signed [TEMP_W-1:0] lim_trip,
   output logic                     therm,
   output logic                     flag_trip
);
   localparam int EXT_W = TEMP_W + 1;
   localparam logic signed [EXT_W-1:0] HYST_V = EXT_W'(HYST);

   if (HYST < 0 || HYST >= (2 ** (TEMP_W-1))) begin : g_bad_hyst
      $error("tmon_trip_hyst: HYST out of range");
   end

   logic signed [EXT_W-1:0] rel_thr;
   logic signed [EXT_W-1:0] corr_ext;
   logic                    hit;
   logic                    rel;

   always_comb begin
      rel_thr  = {lim_trip[TEMP_W-1], lim_trip} - HYST_V;
      corr_ext = {corr_c[TEMP_W-1], corr_c};
      hit      = smp && (corr_c >= lim_trip);
      rel      = smp && (corr_ext < rel_thr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm     <= 1'b0;
         flag_trip <= 1'b0;
      end else begin
         if (hit) therm <= 1'b1;
         else if (rel) therm <= 1'b0;
         flag_trip <= hit | (flag_trip & ~clr);
      end
   end

   assert_rise_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(therm) |-> $past(smp));
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !smp |=> $stable(therm));
   assert_flag_with_therm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (therm && flag_trip));
endmodule

// File: rtl/tmon_limit_check.sv
module tmon_limit_check #(
   parameter int TEMP_W    = 8,
   parameter int OFS_W     = 5,
   parameter int HYST      = 5,
   parameter bit SYM_CLAMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] raw_temp,
   input  logic              raw_vld,
   input  logic [OFS_W-1:0]  ofs_code,
   input  logic [TEMP_W-1:0] lim_hi,
   input  logic [TEMP_W-1:0] lim_lo,
   input  logic [TEMP_W-1:0] lim_trip,
   input  logic              sts_clr,
   output logic [TEMP_W-1:0] corr_temp,
   output logic              corr_vld,
   output logic              flag_hi,
   output logic              flag_lo,
   output logic              flag_trip,
   output logic              therm_o
);
   if (TEMP_W < 4) begin : g_bad_temp_w
      $error("tmon_limit_check: TEMP_W too small");
   end

   logic signed [TEMP_W-1:0] corr_c;
   logic signed [TEMP_W-1:0] corr_q;
   tmon_pkg::win_flags_t     wflags;

   tmon_ofs_add #(.TEMP_W(TEMP_W), .OFS_W(OFS_W), .SYM_CLAMP(SYM_CLAMP)) u_ofs (
      .clk(clk), .rst_n(rst_n), .raw(raw_temp), .raw_vld(raw_vld),
      .ofs_code(ofs_code), .corr_c(corr_c), .corr_q(corr_q), .vld_q(corr_vld)
   );

   tmon_window_cmp #(.TEMP_W(TEMP_W)) u_win (
      .clk(clk), .rst_n(rst_n), .smp(raw_vld), .clr(sts_clr), .corr_c(corr_c),
      .lim_hi(lim_hi), .lim_lo(lim_lo), .flags(wflags)
   );

   tmon_trip_hyst #(.TEMP_W(TEMP_W), .HYST(HYST)) u_trip (
      .clk(clk), .rst_n(rst_n), .smp(raw_vld), .clr(sts_clr), .corr_c(corr_c),
      .lim_trip(lim_trip), .therm(therm_o), .flag_trip(flag_trip)
   );

   assign corr_temp = corr_q;
   assign flag_hi   = wflags.hi;
   assign flag_lo   = wflags.lo;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (corr_temp == '0 && !therm_o && !flag_hi && !flag_lo && !flag_trip));
endmodule

// File: tb/test_tmon_limit_check.sv
module test_tmon_limit_check;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] raw_temp = '0;
   logic       raw_vld = 1'b0;
   logic [4:0] ofs_code = '0;
   logic [7:0] lim_hi = 8'd40;
   logic [7:0] lim_lo = 8'hEC;   // -20
   logic [7:0] lim_trip = 8'd60;
   logic       sts_clr = 1'b0;
   logic [7:0] corr_temp;
   logic       corr_vld, flag_hi, flag_lo, flag_trip, therm_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit therm_m = 1'b0;

   always #5ns clk = ~clk;

   tmon_limit_check i_tmon_limit_check (
      .clk(clk), .rst_n(rst_n), .raw_temp(raw_temp), .raw_vld(raw_vld),
      .ofs_code(ofs_code), .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_trip(lim_trip),
      .sts_clr(sts_clr), .corr_temp(corr_temp), .corr_vld(corr_vld),
      .flag_hi(flag_hi), .flag_lo(flag_lo), .flag_trip(flag_trip), .therm_o(therm_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_corr(input int raw, input int code);
      int ofs = (code >= 16) ? code - 32 : code;
      int s;
      if (ofs == -16) ofs = -15;
      s = raw + ofs;
      if (s > 127) s = 127;
      if (s < -128) s = -128;
      return s;
   endfunction

   // One sample: inputs driven on a falling edge, results read on the next falling edge.
   task automatic sample(input int raw, input int code, input bit clr);
      @(negedge clk);
      raw_temp = 8'(raw);
      ofs_code = 5'(code);
      raw_vld  = 1'b1;
      sts_clr  = clr;
      @(negedge clk);
      raw_vld  = 1'b0;
      sts_clr  = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 corr_temp", int'(corr_temp), 0);
      check("R1 flags", int'({flag_hi, flag_lo, flag_trip, therm_o, corr_vld}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", int'({flag_hi, flag_lo, flag_trip, therm_o}), 0);

      // Exhaustive sweep with a clear pulse on every sample: R2 R3 R4 R5 R7 R8.
      for (int code = 0; code < 32; code++) begin
         for (int raw = -128; raw < 128; raw++) begin
            int e;
            sample(raw, code, 1'b1);
            e = model_corr(raw, code);
            if (e >= 60) therm_m = 1'b1;
            else if (e < 55) therm_m = 1'b0;
            check("R2 R3 corr_temp", int'($signed(corr_temp)), e);
            check("R4 flag_hi", int'(flag_hi), int'(e > 40));
            check("R5 flag_lo", int'(flag_lo), int'(e < -20));
            check("R7 flag_trip", int'(flag_trip), int'(e >= 60));
            check("R8 therm_o", int'(therm_o), int'(therm_m));
            check("R9 corr_vld", int'(corr_vld), 1);
         end
      end

      // R6: stickiness, then a standalone clear.
      sample(100, 0, 1'b1);
      sample(0, 0, 1'b0);
      check("R6 hi sticky", int'(flag_hi), 1);
      check("R6 trip sticky", int'(flag_trip), 1);
      @(negedge clk);
      sts_clr = 1'b1;
      @(negedge clk);
      sts_clr = 1'b0;
      check("R6 cleared", int'({flag_hi, flag_lo, flag_trip}), 0);
      // R6: clear together with a violation keeps the flag set.
      sample(-100, 0, 1'b1);
      check("R6 clr+viol lo", int'(flag_lo), 1);

      // R9: idle input changes have no effect.
      sample(70, 0, 1'b1);
      check("R9 corr before", int'($signed(corr_temp)), 70);
      @(negedge clk);
      raw_temp = 8'h81;
      ofs_code = 5'd15;
      check("R9 corr_vld low", int'(corr_vld), 0);
      repeat (3) @(negedge clk);
      check("R9 corr held", int'($signed(corr_temp)), 70);
      check("R9 therm held", int'(therm_o), 1);
      check("R9 flags held", int'({flag_hi, flag_lo, flag_trip}), 3'b101);

      // R8: band between release threshold and trip limit holds therm_o.
      sample(56, 0, 1'b0);
      check("R8 hold in band", int'(therm_o), 1);
      sample(55, 0, 1'b0);
      check("R8 hold at thr", int'(therm_o), 1);
      sample(54, 0, 1'b0);
      check("R8 release", int'(therm_o), 0);
      sample(59, 0, 1'b0);
      check("R7 below limit", int'(therm_o), 0);
      sample(60, 0, 1'b0);
      check("R7 at limit", int'(therm_o), 1);

      // R8: trip limit near the bottom never releases (no wrap of limit minus 5).
      lim_trip = 8'h83;   // -125
      sample(-120, 0, 1'b1);
      check("R8 low trip set", int'(therm_o), 1);
      sample(-128, 0, 1'b1);
      check("R8 low trip no wrap", int'(therm_o), 1);
      sample(-128, 16, 1'b1);
      check("R3 R2 floor", int'($signed(corr_temp)), -128);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule